// File: doc/BRIEF.md
# Mirrored Per-Queue Transmit Byte-Count Table

The block keeps one table of frame byte counts for each of several transmit descriptor rings. Each ring holds 256 descriptors, and its table has 320 slots of 16 bits. A producer posts a queue number, a descriptor index and a 12-bit frame length. The block stores the length in the slot that matches the index. When the index falls in the lowest 64 positions, the block writes the same value a second time, 256 slots higher, on the next cycle. A consumer such as a transmit scheduler can then read a window of up to 64 consecutive slots from any start index in a straight line, without folding the address at the ring boundary.

Alongside the table, the block keeps an enqueue pointer and a dequeue pointer for each ring and exposes how many entries are pending. A ring never holds more than 255 pending entries. A post to a ring at that level is refused, and the refusal is flagged in the same cycle. The consumer retires entries through a dequeue strobe. The read port takes one slot address per cycle and answers one cycle later.

Top module: `txq_bytecnt_table`

## Requirements
- R1: After synchronous reset every ring reports zero pending entries: q_empty is all ones, q_full is all zeros and lvl_count is 0. Also wr_ready is 1, wr_error is 0, rd_valid is 0 and rd_data is 0.
- R2: A post is accepted when wr_valid and wr_ready are both 1 and the addressed ring is not full. An accepted post stores wr_bytes in slot wr_index of table wr_queue, and a later read of that slot returns it.
- R3: An accepted post with wr_index below 64 also stores the same value in slot wr_index+256 during the next cycle. wr_ready is 0 in that cycle, and a post presented during it is neither taken nor flagged.
- R4: An accepted post with wr_index of 64 or more writes only the primary slot, and wr_ready stays 1 in the following cycle.
- R5: A read request (rd_en with rd_slot below 320) gives rd_valid = 1 in the next cycle. rd_data[11:0] then holds the slot's content as it was before that edge, and rd_data[15:12] is 0.
- R6: A read request with rd_slot of 320 or more gives rd_valid = 0 and rd_data = 0 in the next cycle.
- R7: The pending count of a ring rises by one for each accepted post and falls by one for each effective dequeue. A post and a dequeue to the same ring in the same cycle leave the count unchanged. lvl_count shows the count of the ring chosen by lvl_queue.
- R8: A ring with 255 pending entries reports q_full = 1. A post presented to it while wr_ready is 1 raises wr_error in that cycle and changes neither the table nor the count.
- R9: A dequeue to a ring with zero pending entries has no effect; the count stays 0 and q_empty stays 1.
- R10: Posts, mirrors and dequeues to one ring leave every other ring's table and count untouched.
- R11: Reading slots s to s+63 of a ring, with s+63 below 320, returns the ring's entries for indexes s mod 256 upward in order. Past slot 255 these are the values posted at indexes 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A post is offered |
| wr_ready | output | 1 | Block can take a post this cycle (0 during a mirror write) |
| wr_queue | input | 4 | Ring number of the post |
| wr_index | input | 8 | Descriptor index of the post |
| wr_bytes | input | 12 | Frame byte count to store |
| wr_error | output | 1 | Post refused because its ring is full |
| deq_valid | input | 1 | Retire one pending entry |
| deq_queue | input | 4 | Ring to retire from |
| rd_en | input | 1 | Read request |
| rd_queue | input | 4 | Ring to read |
| rd_slot | input | 9 | Table slot to read, 0 to 319 valid |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 16 | Table entry, byte count in bits [11:0] |
| q_full | output | 16 | Per-ring flag: 255 entries pending |
| q_empty | output | 16 | Per-ring flag: nothing pending |
| lvl_queue | input | 4 | Ring whose pending count is shown |
| lvl_count | output | 8 | Pending count of ring lvl_queue |

## Verification
Posts are tried at high indexes, where no mirror should appear and wr_ready must not drop, and at low indexes, where a second write and a one-cycle stall must both appear. A third case offers a post during the stall, which tells a correctly held handshake from one that swallows or double-writes. One ring is filled to its 255 limit to separate the refusal path from a counter that wraps. A 64-slot window read across the ring boundary shows whether the mirror slots hold the low-index values. Same-cycle post and dequeue, a dequeue on an empty ring, and traffic on neighbouring rings tell a correct per-ring counter from one that is shared or underflows.

// File: rtl/bct_pkg.sv
package bct_pkg;
    parameter int NUM_Q     = 16;
    parameter int RING      = 256;
    parameter int WIN       = 64;
    parameter int CNT_W     = 12;
    parameter int ENT_W     = 16;

    localparam int TBL_DEPTH = RING + WIN;
    localparam int QW        = $clog2(NUM_Q);
    localparam int IW        = $clog2(RING);
    localparam int SW        = $clog2(TBL_DEPTH);
    localparam int MAX_PEND  = RING - 1;

    typedef struct packed {
        logic [QW-1:0]    q;
        logic [SW-1:0]    slot;
        logic [CNT_W-1:0] bytes;
    } wr_op_t;

    function automatic logic needs_mirror(input logic [IW-1:0] idx);
        return 32'(idx) < WIN;
    endfunction

    function automatic logic [SW-1:0] mirror_slot(input logic [IW-1:0] idx);
        return SW'(idx) + SW'(RING);
    endfunction
endpackage

// File: rtl/bct_write_seq.sv
module bct_write_seq
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [QW-1:0]    wr_queue,
    input  logic [IW-1:0]    wr_index,
    input  logic [CNT_W-1:0] wr_bytes,
    input  logic             sel_full,
    output logic             wr_ready,
    output logic             wr_accept,
    output logic             wr_error,
    output logic             mem_we,
    output wr_op_t           mem_op
);
    logic   mir_pend;
    wr_op_t mir_op;
    wr_op_t new_op;

    assign wr_ready  = !mir_pend;
    assign wr_accept = wr_valid && !mir_pend && !sel_full;
    assign wr_error  = wr_valid && !mir_pend && sel_full;

    always_comb begin
        new_op.q     = wr_queue;
        new_op.slot  = SW'(wr_index);
        new_op.bytes = wr_bytes;
        mem_we       = mir_pend || wr_accept;
        mem_op       = mir_pend ? mir_op : new_op;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mir_pend <= 1'b0;
            mir_op   <= '0;
        end else if (wr_accept && needs_mirror(wr_index)) begin
            mir_pend     <= 1'b1;
            mir_op.q     <= wr_queue;
            mir_op.slot  <= mirror_slot(wr_index);
            mir_op.bytes <= wr_bytes;
        end else begin
            mir_pend <= 1'b0;
        end
    end

    // R3: a low-index post stalls the port for the mirror cycle
    p_mirror_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && 32'(wr_index) < WIN) |=> (!wr_ready && mem_we));
    // R4: a high-index post does not stall
    p_no_mirror_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && 32'(wr_index) >= WIN) |=> wr_ready);
    // R3: the mirror copy lands 256 slots above the primary one
    p_mirror_slot_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && 32'(wr_index) < WIN) |=>
        (32'(mem_op.slot) == 32'($past(wr_index)) + RING && mem_op.bytes == $past(wr_bytes)));
endmodule

// File: rtl/bct_ring_ctrl.sv
module bct_ring_ctrl
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enq,
    input  logic [QW-1:0]    enq_q,
    input  logic             deq_valid,
    input  logic [QW-1:0]    deq_q,
    input  logic [QW-1:0]    lvl_q,
    output logic [NUM_Q-1:0] q_full,
    output logic [NUM_Q-1:0] q_empty,
    output logic [IW-1:0]    lvl_count
);
    logic [IW-1:0] occ [NUM_Q];

    for (genvar g = 0; g < NUM_Q; g++) begin : g_ring
        logic [IW-1:0] enq_ptr;
        logic [IW-1:0] deq_ptr;
        logic          do_enq;
        logic          do_deq;

        assign occ[g]     = enq_ptr - deq_ptr;
        assign q_full[g]  = (32'(occ[g]) == MAX_PEND);
        assign q_empty[g] = (occ[g] == '0);
        assign do_enq     = enq && (32'(enq_q) == g);
        assign do_deq     = deq_valid && (32'(deq_q) == g) && !q_empty[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                enq_ptr <= '0;
                deq_ptr <= '0;
            end else begin
                if (do_enq) enq_ptr <= enq_ptr + 1'b1;
                if (do_deq) deq_ptr <= deq_ptr + 1'b1;
            end
        end

        // R7: the count moves by at most one per cycle
        p_step_r7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((IW'(occ[g] - $past(occ[g])) <= IW'(1)) ||
                      (IW'(occ[g] - $past(occ[g])) == {IW{1'b1}})));
        // R8: a full ring never wraps to empty
        p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
            q_full[g] |=> !q_empty[g]);
        // R9: dequeue on an empty ring with no post keeps it empty
        p_empty_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (q_empty[g] && !(enq && 32'(enq_q) == g)) |=> q_empty[g]);
    end

    assign lvl_count = occ[lvl_q];
endmodule

// File: rtl/bct_store.sv
module bct_store
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  wr_op_t           op,
    input  logic             rd_en,
    input  logic [QW-1:0]    rd_q,
    input  logic [SW-1:0]    rd_slot,
    output logic             rd_valid,
    output logic [ENT_W-1:0] rd_data
);
    logic [CNT_W-1:0] mem [NUM_Q][TBL_DEPTH];
    logic             in_range;

    assign in_range = 32'(rd_slot) < TBL_DEPTH;

    always_ff @(posedge clk) begin
        if (we) mem[op.q][op.slot] <= op.bytes;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en && in_range;
            rd_data  <= (rd_en && in_range) ? ENT_W'(mem[rd_q][rd_slot]) : '0;
        end
    end

    // R5: in-range request answers one cycle later with clear top bits
    p_rd_lat_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && 32'(rd_slot) < TBL_DEPTH) |=> (rd_valid && rd_data[ENT_W-1:CNT_W] == '0));
    // R6: out-of-range request gives nothing
    p_rd_oob_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && 32'(rd_slot) >= TBL_DEPTH) |=> (!rd_valid && rd_data == '0));
endmodule

// File: rtl/txq_bytecnt_table.sv
module txq_bytecnt_table
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [QW-1:0]    wr_queue,
    input  logic [IW-1:0]    wr_index,
    input  logic [CNT_W-1:0] wr_bytes,
    output logic             wr_error,
    input  logic             deq_valid,
    input  logic [QW-1:0]    deq_queue,
    input  logic             rd_en,
    input  logic [QW-1:0]    rd_queue,
    input  logic [SW-1:0]    rd_slot,
    output logic             rd_valid,
    output logic [ENT_W-1:0] rd_data,
    output logic [NUM_Q-1:0] q_full,
    output logic [NUM_Q-1:0] q_empty,
    input  logic [QW-1:0]    lvl_queue,
    output logic [IW-1:0]    lvl_count
);
    logic   wr_accept;
    logic   mem_we;
    wr_op_t mem_op;

    bct_write_seq u_wseq (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_queue  (wr_queue),
        .wr_index  (wr_index),
        .wr_bytes  (wr_bytes),
        .sel_full  (q_full[wr_queue]),
        .wr_ready  (wr_ready),
        .wr_accept (wr_accept),
        .wr_error  (wr_error),
        .mem_we    (mem_we),
        .mem_op    (mem_op)
    );

    bct_ring_ctrl u_rings (
        .clk       (clk),
        .rst       (rst),
        .enq       (wr_accept),
        .enq_q     (wr_queue),
        .deq_valid (deq_valid),
        .deq_q     (deq_queue),
        .lvl_q     (lvl_queue),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .lvl_count (lvl_count)
    );

    bct_store u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (mem_we),
        .op       (mem_op),
        .rd_en    (rd_en),
        .rd_q     (rd_queue),
        .rd_slot  (rd_slot),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R8: a refused post never coincides with an accepted one
    p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_error && wr_accept));
    // R8: a refused post leaves the pending count of its ring unchanged
    p_err_keeps_full_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_error && !(deq_valid && deq_queue == wr_queue)) |=> q_full[$past(wr_queue)]);
endmodule

// File: tb/txq_bytecnt_table_bench.sv
module txq_bytecnt_table_bench;
    import bct_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             wr_valid = 0, wr_ready, wr_error;
    logic [QW-1:0]    wr_queue = 0;
    logic [IW-1:0]    wr_index = 0;
    logic [CNT_W-1:0] wr_bytes = 0;
    logic             deq_valid = 0;
    logic [QW-1:0]    deq_queue = 0;
    logic             rd_en = 0;
    logic [QW-1:0]    rd_queue = 0;
    logic [SW-1:0]    rd_slot = 0;
    logic             rd_valid;
    logic [ENT_W-1:0] rd_data;
    logic [NUM_Q-1:0] q_full, q_empty;
    logic [QW-1:0]    lvl_queue = 0;
    logic [IW-1:0]    lvl_count;

    txq_bytecnt_table u_txq_bytecnt_table (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    int m_mem [NUM_Q][TBL_DEPTH];
    int m_cnt [NUM_Q];
    bit m_mpend;
    int m_mq, m_ms, m_md;
    bit m_rv;
    int m_rd;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        for (int q = 0; q < NUM_Q; q++)
            for (int s = 0; s < TBL_DEPTH; s++) m_mem[q][s] = -1;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_mpend = 0; m_rv = 0; m_rd = 0;
            for (int q = 0; q < NUM_Q; q++) m_cnt[q] = 0;
        end else begin
            bit acc, dq;
            acc = wr_valid && !m_mpend && m_cnt[wr_queue] != MAX_PEND;
            dq  = deq_valid && m_cnt[deq_queue] != 0;
            if (rd_en && int'(rd_slot) < TBL_DEPTH) begin
                m_rv = 1; m_rd = m_mem[rd_queue][rd_slot];
            end else begin
                m_rv = 0; m_rd = 0;
            end
            if (m_mpend) begin
                m_mem[m_mq][m_ms] = m_md;
                m_mpend = 0;
            end
            if (acc) begin
                m_mem[wr_queue][wr_index] = int'(wr_bytes);
                if (int'(wr_index) < WIN) begin
                    m_mpend = 1; m_mq = wr_queue;
                    m_ms = int'(wr_index) + RING; m_md = int'(wr_bytes);
                end
                m_cnt[wr_queue]++;
            end
            if (dq) m_cnt[deq_queue]--;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R3 wr_ready", int'(wr_ready), int'(!m_mpend));
            chk("R8 wr_error", int'(wr_error),
                int'(wr_valid && !m_mpend && m_cnt[wr_queue] == MAX_PEND));
            chk("R6 rd_valid", int'(rd_valid), int'(m_rv));
            if (m_rd >= 0) chk("R2 rd_data", int'(rd_data), m_rd);
            chk("R7 lvl_count", int'(lvl_count), m_cnt[lvl_queue]);
            for (int q = 0; q < NUM_Q; q++) begin
                chk("R8 q_full", int'(q_full[q]), int'(m_cnt[q] == MAX_PEND));
                chk("R9 q_empty", int'(q_empty[q]), int'(m_cnt[q] == 0));
            end
        end
    end

    function automatic int fpat(int i);
        return (i * 7 + 1) & 12'hFFF;
    endfunction

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic do_write(int q, int i, int b);
        wr_valid = 1; wr_queue = QW'(q); wr_index = IW'(i); wr_bytes = CNT_W'(b);
        #1;
        while (!wr_ready) begin tick(); #1; end
        tick();
        wr_valid = 0;
    endtask

    task automatic do_read(int q, int s, output int data, output int valid);
        rd_en = 1; rd_queue = QW'(q); rd_slot = SW'(s);
        tick();
        rd_en = 0;
        data = int'(rd_data); valid = int'(rd_valid);
    endtask

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 200000, 0);
        summary();
    end

    initial begin
        int d, v;
        repeat (3) tick();
        rst = 0;
        #1;
        // R1: reset state
        chk("R1 wr_ready", int'(wr_ready), 1);
        chk("R1 q_empty", int'(q_empty), 32'h0000FFFF);
        chk("R1 q_full", int'(q_full), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        tick();

        // R2/R4: high-index post, no stall
        lvl_queue = 3;
        do_write(3, 100, 12'hABC);
        chk("R4 ready after high post", int'(wr_ready), 1);
        do_read(3, 100, d, v);
        chk("R2 readback", d, 12'hABC);
        chk("R5 rd_valid", v, 1);
        chk("R5 top bits zero", d >> CNT_W, 0);
        do_read(3, 356, d, v);
        chk("R4 no mirror written", int'(d == 12'hABC), 0);

        // R3: low-index post mirrors, stalls, and drops a post in the stall
        wr_valid = 1; wr_queue = 5; wr_index = 10; wr_bytes = 12'h123;
        tick();
        chk("R3 stall", int'(wr_ready), 0);
        wr_index = 120; wr_bytes = 12'h777;
        tick();
        wr_valid = 0;
        chk("R3 ready back", int'(wr_ready), 1);
        lvl_queue = 5;
        #1 chk("R3 dropped post not counted", int'(lvl_count), 1);
        do_read(5, 266, d, v);
        chk("R3 mirror slot", d, 12'h123);
        do_read(5, 10, d, v);
        chk("R3 primary slot", d, 12'h123);

        // R10: ring 3 untouched by ring 5 traffic
        lvl_queue = 3;
        #1 chk("R10 ring3 count", int'(lvl_count), 1);
        do_read(3, 100, d, v);
        chk("R10 ring3 data", d, 12'hABC);

        // R7: same-cycle post and dequeue on ring 3
        wr_valid = 1; wr_queue = 3; wr_index = 70; wr_bytes = 12'h055;
        deq_valid = 1; deq_queue = 3;
        tick();
        wr_valid = 0; deq_valid = 0;
        chk("R7 post+deq keeps count", int'(lvl_count), 1);

        // R9: dequeue on empty ring 9
        lvl_queue = 9;
        deq_valid = 1; deq_queue = 9;
        tick();
        deq_valid = 0;
        chk("R9 count stays zero", int'(lvl_count), 0);
        chk("R9 empty flag", int'(q_empty[9]), 1);

        // R8: fill ring 2 to 255
        lvl_queue = 2;
        for (int i = 0; i < MAX_PEND; i++) do_write(2, i, fpat(i));
        #1;
        while (!wr_ready) begin tick(); #1; end
        chk("R8 level 255", int'(lvl_count), MAX_PEND);
        chk("R8 full flag", int'(q_full[2]), 1);
        wr_valid = 1; wr_queue = 2; wr_index = 0; wr_bytes = 12'hFFF;
        #1 chk("R8 error pulse", int'(wr_error), 1);
        tick();
        wr_valid = 0;
        chk("R8 count held", int'(lvl_count), MAX_PEND);
        do_read(2, 0, d, v);
        chk("R8 table untouched", d, fpat(0));
        deq_valid = 1; deq_queue = 2;
        tick();
        deq_valid = 0;
        do_write(2, 255, fpat(255));
        chk("R8 post after retire", int'(lvl_count), MAX_PEND);

        // R11: window across the ring boundary
        for (int k = 0; k < WIN; k++) begin
            rd_en = 1; rd_queue = 2; rd_slot = SW'(200 + k);
            tick();
            chk("R11 window", int'(rd_data), fpat((200 + k) % RING));
        end
        rd_en = 0;

        // R6: out-of-range reads
        do_read(2, 320, d, v);
        chk("R6 oob valid", v, 0);
        chk("R6 oob data", d, 0);
        do_read(2, 511, d, v);
        chk("R6 oob top", v, 0);
        do_read(2, 319, d, v);
        chk("R5 last slot", d, fpat(63));

        repeat (3) tick();
        summary();
    end
endmodule